// File: doc/BRIEF.md
# UART Transmit Clear-to-Send Gate

This block sits between a UART transmit FIFO and its serializer and decides when the serializer may take the next character. The modem clear-to-send input is active low and arrives asynchronously. When hardware flow control is enabled, the gate samples the synchronized clear-to-send level at one instant per character: the mid-bit tick of the final stop bit. If the line was inactive then, the next character is held back. The character already on the wire is always finished. Transmission resumes when the synchronized line goes low again. When flow control is disabled, the line is ignored and the FIFO drains freely.

The gate also gives the interrupt logic a mask. While flow control is enabled, clear-to-send changes must not raise a modem-status interrupt, because the transmitter already handles them. The baud generator, the serializer and the FIFO storage are outside this block. It reads only their status: the serializer busy flag, a last-stop-bit flag and a mid-bit tick.

The controller has five states:
- `GT_IDLE`: no character is in flight.
- `GT_LAUNCH`: a start was issued and the gate waits for the busy flag.
- `GT_SEND`: a character is being shifted.
- `GT_CLEAR`: the verdict at mid-stop was "go".
- `GT_HOLD`: the verdict was "stop".

Its transitions are:
- IDLE→LAUNCH when it starts a character.
- LAUNCH→SEND when busy rises.
- SEND→CLEAR or SEND→HOLD at the mid-stop sample.
- SEND→IDLE if busy drops with no sample taken.
- CLEAR→LAUNCH when it starts back to back.
- CLEAR→IDLE when the FIFO is empty at the end of the character.
- HOLD→IDLE when the hold is released.

Top module: `uart_cts_gate`

## Requirements
- R1: Reset puts the controller in GT_IDLE with no hold pending. Reset also presets the synchronizer to the inactive level (high). So with flow_en high, start_next stays low for the first two clocks after reset even if cts_n_pin is already low.
- R2: cts_n_pin passes through a two-flop synchronizer. A change on the pin can change start_next no earlier than the second rising edge after the change.
- R3: In GT_IDLE with ser_busy low, start_next is high exactly when fifo_nonempty is high and either flow_en is low or the synchronized CTS is low.
- R4: On the cycle where ser_busy, ser_last_stop and ser_mid_tick are all high, the gate records a verdict. The verdict is "go" if flow_en is low or the synchronized CTS is low. After a "go" verdict, start_next rises on the first cycle ser_busy is low while fifo_nonempty is high. Later CTS changes do not affect this.
- R5: After a "stop" verdict, start_next stays low until the synchronized CTS is low (or flow_en is low) with ser_busy low. The gate then returns to GT_IDLE one cycle later and follows R3.
- R6: start_next is never high while ser_busy is high, so a character in flight is never disturbed.
- R7: start_next is a single-cycle pulse. After a pulse, no further pulse comes until ser_busy has risen and a new decision is made.
- R8: With flow_en low, the level of cts_n_pin has no effect: every queued character is sent back to back.
- R9: cts_irq_mask equals flow_en in the same cycle, masking CTS-change interrupts while flow control is on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cts_n_pin | input | 1 | Clear-to-send line, active low, asynchronous |
| flow_en | input | 1 | Hardware flow-control enable |
| fifo_nonempty | input | 1 | Transmit FIFO holds at least one character |
| ser_busy | input | 1 | Serializer is shifting a character |
| ser_last_stop | input | 1 | Serializer is in its final stop bit |
| ser_mid_tick | input | 1 | Mid-bit strobe from the serializer |
| start_next | output | 1 | One-cycle permit to pop and start the next character |
| cts_irq_mask | output | 1 | Suppress CTS-change interrupts |

## Verification
Assertions check three things on every cycle: a start never overlaps a busy serializer, start pulses last one cycle, and a "stop" verdict is followed by silence on start_next and a "go" verdict by the clear state. Only the bench scenarios can show the timing relations with the pin. These are the two-clock synchronizer lag after reset, the fact that a CTS release just after the mid-stop tick still lets the next character go, the release of a hold, and the indifference to CTS when flow control is off. The bench's reference model predicts start_next on every clock and counts the characters sent.

// File: rtl/uart_cts_gate_pkg.sv
package uart_cts_gate_pkg;

    typedef enum logic [2:0] {
        GT_IDLE   = 3'd0,
        GT_LAUNCH = 3'd1,
        GT_SEND   = 3'd2,
        GT_CLEAR  = 3'd3,
        GT_HOLD   = 3'd4
    } gate_state_e;

    localparam int unsigned SYNC_DEPTH_DEFAULT = 2;

endpackage

// File: rtl/uart_cts_sync.sv
module uart_cts_sync #(
    parameter int unsigned STAGES    = 2,
    parameter logic        RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    localparam int unsigned LAST = STAGES - 1;

    logic [LAST:0] chain_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= RESET_VAL;
                    else        chain_q[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= RESET_VAL;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain_q[LAST];

endmodule

// File: rtl/uart_cts_gate_fsm.sv
module uart_cts_gate_fsm
    import uart_cts_gate_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cts_n_s,
    input  logic flow_en,
    input  logic fifo_nonempty,
    input  logic ser_busy,
    input  logic ser_last_stop,
    input  logic ser_mid_tick,
    output logic start_next
);

    gate_state_e state_q, state_d;
    logic        cts_ok;
    logic        stop_sample;

    assign cts_ok      = !flow_en || !cts_n_s;
    assign stop_sample = ser_busy && ser_last_stop && ser_mid_tick;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= GT_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GT_IDLE: begin
                if (!ser_busy && fifo_nonempty && cts_ok) state_d = GT_LAUNCH;
            end
            GT_LAUNCH: begin
                if (ser_busy) state_d = GT_SEND;
            end
            GT_SEND: begin
                if (stop_sample)    state_d = cts_ok ? GT_CLEAR : GT_HOLD;
                else if (!ser_busy) state_d = GT_IDLE;
            end
            GT_CLEAR: begin
                if (!ser_busy) state_d = fifo_nonempty ? GT_LAUNCH : GT_IDLE;
            end
            GT_HOLD: begin
                if (!ser_busy && cts_ok) state_d = GT_IDLE;
            end
            default: state_d = GT_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        start_next = 1'b0;
        unique case (state_q)
            GT_IDLE:   start_next = !ser_busy && fifo_nonempty && cts_ok;
            GT_CLEAR:  start_next = !ser_busy && fifo_nonempty;
            GT_LAUNCH,
            GT_SEND,
            GT_HOLD:   start_next = 1'b0;
            default:   start_next = 1'b0;
        endcase
    end

    p_no_start_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        start_next |-> !ser_busy)
        else $error("start issued while serializer busy");

    p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        start_next |=> !start_next)
        else $error("start held for more than one cycle");

    p_stop_verdict_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GT_SEND && stop_sample && !cts_ok) |=> (state_q == GT_HOLD && !start_next))
        else $error("stop verdict did not hold transmitter");

    p_go_verdict_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GT_SEND && stop_sample && cts_ok) |=> (state_q == GT_CLEAR))
        else $error("go verdict not recorded");

endmodule

// File: rtl/uart_cts_gate.sv
module uart_cts_gate
    import uart_cts_gate_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = SYNC_DEPTH_DEFAULT
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cts_n_pin,
    input  logic flow_en,
    input  logic fifo_nonempty,
    input  logic ser_busy,
    input  logic ser_last_stop,
    input  logic ser_mid_tick,
    output logic start_next,
    output logic cts_irq_mask
);

    logic cts_n_s;

    uart_cts_sync #(
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b1)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (cts_n_pin),
        .sync_out (cts_n_s)
    );

    uart_cts_gate_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .cts_n_s       (cts_n_s),
        .flow_en       (flow_en),
        .fifo_nonempty (fifo_nonempty),
        .ser_busy      (ser_busy),
        .ser_last_stop (ser_last_stop),
        .ser_mid_tick  (ser_mid_tick),
        .start_next    (start_next)
    );

    assign cts_irq_mask = flow_en;

endmodule

// File: tb/test_uart_cts_gate.sv
module test_uart_cts_gate;

    localparam int FRAME = 20;
    localparam int WATCHDOG_NS = 400000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cts_n_pin = 1'b1;
    logic flow_en = 1'b0;
    logic fifo_nonempty = 1'b0;
    logic ser_busy = 1'b0;
    logic ser_last_stop = 1'b0;
    logic ser_mid_tick = 1'b0;
    logic start_next;
    logic cts_irq_mask;

    always #2 clk = ~clk;

    uart_cts_gate i_uart_cts_gate (
        .clk           (clk),
        .rst_n         (rst_n),
        .cts_n_pin     (cts_n_pin),
        .flow_en       (flow_en),
        .fifo_nonempty (fifo_nonempty),
        .ser_busy      (ser_busy),
        .ser_last_stop (ser_last_stop),
        .ser_mid_tick  (ser_mid_tick),
        .start_next    (start_next),
        .cts_irq_mask  (cts_irq_mask)
    );

    int tests = 0;
    int fails = 0;

    // stimulus
    logic st_rst = 1'b0, st_cts = 1'b1, st_fe = 1'b0;
    int   fifo_cnt = 0;
    int   sent = 0;

    // serializer model
    bit ser_on = 0;
    int bitc = 0;

    // reference model
    bit m_s1 = 1, m_s2 = 1;
    int m_ph = 0; // 0 free, 1 awaiting busy, 2 sending, 3 go, 4 stop
    bit m_start;

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic step();
        bit okc;
        string tag;
        @(negedge clk);
        rst_n         = st_rst;
        cts_n_pin     = st_cts;
        flow_en       = st_fe;
        fifo_nonempty = (fifo_cnt > 0);
        ser_busy      = ser_on;
        ser_last_stop = ser_on && (bitc >= 16);
        ser_mid_tick  = ser_on && (bitc % 4 == 2);
        #1;
        okc = !st_fe || !m_s2;
        m_start = 0;
        if (st_rst) begin
            if (m_ph == 0) m_start = !ser_on && fifo_nonempty && okc;
            if (m_ph == 3) m_start = !ser_on && fifo_nonempty;
        end
        case (m_ph)
            0: tag = st_fe ? "R3" : "R8";
            3: tag = "R4";
            4: tag = "R5";
            default: tag = "R6";
        endcase
        if (!st_rst) tag = "R1";
        check(start_next === m_start, tag, "start_next", start_next, m_start);
        check(cts_irq_mask === st_fe, "R9", "cts_irq_mask", cts_irq_mask, st_fe);
        @(posedge clk);
        if (!st_rst) begin
            m_s1 = 1; m_s2 = 1; m_ph = 0;
        end else begin
            case (m_ph)
                0: if (m_start) m_ph = 1;
                1: if (ser_on) m_ph = 2;
                2: if (ser_last_stop && ser_mid_tick) m_ph = okc ? 3 : 4;
                   else if (!ser_on) m_ph = 0;
                3: if (!ser_on) m_ph = fifo_nonempty ? 1 : 0;
                4: if (!ser_on && okc) m_ph = 0;
                default: m_ph = 0;
            endcase
            m_s2 = m_s1;
            m_s1 = st_cts;
        end
        if (ser_on) begin
            bitc++;
            if (bitc == FRAME) ser_on = 0;
        end
        if (m_start) begin
            ser_on = 1; bitc = 0;
            fifo_cnt--; sent++;
        end
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic wait_bit(input int b);
        for (int i = 0; i < 2000; i++) begin
            if (ser_on && bitc == b) return;
            step();
        end
    endtask

    initial begin
        #(WATCHDOG_NS);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        // R1: reset state
        st_rst = 0; st_fe = 0; st_cts = 1; fifo_cnt = 0;
        run(3);
        check(start_next === 1'b0, "R1", "start_next in reset", start_next, 0);
        // R1/R2: release reset with flow on, CTS already low, FIFO full
        st_rst = 1; st_fe = 1; st_cts = 0; fifo_cnt = 1;
        step();
        check(start_next === 1'b0, "R2", "sync lag cycle 1", start_next, 0);
        step();
        check(start_next === 1'b0, "R2", "sync lag cycle 2", start_next, 0);
        step();
        check(start_next === 1'b1, "R3", "start after sync", start_next, 1);
        run(30);
        check(sent == 1, "R3", "chars after reset", sent, 1);

        // R8: flow off, CTS high, three back to back
        sent = 0; st_fe = 0; st_cts = 1; fifo_cnt = 3;
        run(80);
        check(sent == 3, "R8", "chars with flow off", sent, 3);

        // R3: flow on, CTS low
        sent = 0; st_fe = 1; st_cts = 0; fifo_cnt = 3;
        run(80);
        check(sent == 3, "R3", "chars with CTS low", sent, 3);

        // R5: CTS released early in char 1 -> only char 1 sent
        sent = 0; fifo_cnt = 3;
        wait_bit(4);
        st_cts = 1;
        run(60);
        check(sent == 1, "R5", "held after early CTS high", sent, 1);
        check(ser_busy === 1'b0, "R6", "char in flight completed", ser_busy, 0);
        st_cts = 0;
        run(70);
        check(sent == 3, "R5", "resume after CTS low", sent, 3);

        // R4: CTS goes high just after mid-stop sample -> next still starts
        sent = 0; fifo_cnt = 3;
        wait_bit(19);
        st_cts = 1;
        run(60);
        check(sent == 2, "R4", "latched go verdict", sent, 2);

        // R5: flow disable releases hold
        st_fe = 0;
        run(30);
        check(sent == 3, "R5", "release by flow off", sent, 3);

        // R3: idle with CTS high waits, then starts
        sent = 0; st_fe = 1; st_cts = 1; fifo_cnt = 1;
        run(10);
        check(sent == 0, "R3", "idle blocked by CTS high", sent, 0);
        st_cts = 0;
        run(30);
        check(sent == 1, "R3", "idle start after CTS low", sent, 1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule